// File: doc/BRIEF.md
# Windowed Sample Averaging Engine

This block takes a stream of signed values, typically per-sample power products or squared amplitudes from an upstream multiplier. It sums them over a window of N valid samples and then hands out the mean of that window. Examples are the average power over one second, or the mean square that a later stage turns into an RMS figure. One clock edge with the valid strobe high counts as one sample. Cycles without the strobe are ignored.

The window length sits in a length register. It comes out of reset at 4000, which is one second at a 4000 Hz sample rate. A write never sets it below 10. The length is latched on the first sample of each window, so a write never disturbs a window that has already begun.

When a window closes, the accumulator restarts at once. A short sequential divider, which retires two quotient bits per clock, works out the mean in the background. Samples that arrive while the divider runs go into the next window.

Top module: `win_avg_engine`

## Requirements
- R1: While reset is asserted and after it is released, `avg_out` is 0 and `avg_valid` and `win_end` are low. The length register holds 4000.
- R2: A write to the length register with a value below 10, including 0, stores 10. Values of 10 or more are stored unchanged.
- R3: The accumulator never overflows. A window of full-scale samples (all -32768 or all 32767) yields exactly that value as its mean.
- R4: A window closes on the edge that takes its N-th valid sample. `win_end` is high for exactly the one cycle after that edge. Cycles with `smp_valid` low add nothing and do not advance the count.
- R5: `avg_out` equals the window sum divided by N, truncated toward zero. `avg_valid` pulses for one cycle, exactly 8 cycles after `win_end`, and `avg_out` holds its value until the next pulse.
- R6: Valid samples that arrive while the divider is working are not lost. They are summed into the following window, and every window gets its own result.
- R7: A length write takes effect from the first sample of the next window. If the write lands on the same edge as a window's first sample, that window still uses the previous length.
- R8: With no write after reset, the first result covers exactly 4000 valid samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Qualifies `smp_data` on this edge |
| smp_data | input | 16 | Signed sample (product or square) |
| len_wr | input | 1 | Write strobe for the window-length register |
| len_wdata | input | 24 | New window length, clamped to a floor of 10 |
| avg_out | output | 16 | Signed mean of the last completed window |
| avg_valid | output | 1 | One-cycle pulse when `avg_out` is updated |
| win_end | output | 1 | One-cycle flag after the edge that closes a window |

## Verification
The bench goes after these corner cases:

- Full-scale windows of both signs. An accumulator that is one bit short would wrap and give a mean with the wrong sign.
- Small negative sums. A divider that rounds toward minus infinity would report -1 where 0 is correct, or -2 where -1 is correct.
- Length writes of 0 and 3. A missing clamp would give a window shorter than 10 samples.
- Writes in the middle of a window, and writes on the same edge as a window's first sample. A design that loaded the length too early would close those windows at the wrong sample.
- Back-to-back valid samples across window boundaries while the divider is busy. A design that stalled or dropped them would shift every later window boundary.

// File: rtl/wavg_pkg.sv
package wavg_pkg;
  localparam int unsigned DEF_LEN = 4000;
  localparam int unsigned MIN_LEN = 10;
  typedef enum logic {DV_IDLE, DV_RUN} dv_state_e;
endpackage

// File: rtl/wavg_len_reg.sv
module wavg_len_reg #(
  parameter int unsigned LEN_W   = 24,
  parameter int unsigned DEF_LEN = 4000,
  parameter int unsigned MIN_LEN = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LEN_W-1:0] wdata,
  output logic [LEN_W-1:0] len_pend
);
  function automatic logic [LEN_W-1:0] floor_len(input logic [LEN_W-1:0] v);
    return (v < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  len_pend <= LEN_W'(DEF_LEN);
    else if (wr) len_pend <= floor_len(wdata);
  end

  // R2: stored length never below the floor
  p_len_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    len_pend >= LEN_W'(MIN_LEN));
  // R7: length changes only through a write
  p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(len_pend));
endmodule

// File: rtl/wavg_accum.sv
module wavg_accum #(
  parameter int unsigned SMP_W = 16,
  parameter int unsigned LEN_W = 24,
  parameter int unsigned ACC_W = SMP_W + LEN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid,
  input  logic signed [SMP_W-1:0] data,
  input  logic [LEN_W-1:0]        len_pend,
  output logic                    close_o,
  output logic signed [ACC_W-1:0] sum_o,
  output logic [LEN_W-1:0]        len_o
);
  logic signed [ACC_W-1:0] acc;
  logic [LEN_W-1:0]        cnt, len_act, cnt_inc;
  logic                    win_empty;

  assign win_empty = (cnt == '0);
  assign len_o     = win_empty ? len_pend : len_act;
  assign cnt_inc   = cnt + 1'b1;
  assign sum_o     = acc + {{(ACC_W-SMP_W){data[SMP_W-1]}}, data};
  assign close_o   = valid && (cnt_inc == len_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      cnt     <= '0;
      len_act <= '0;
    end else if (valid) begin
      if (win_empty) len_act <= len_pend;
      if (close_o) begin
        acc <= '0;
        cnt <= '0;
      end else begin
        acc <= sum_o;
        cnt <= cnt_inc;
      end
    end
  end

  logic [ACC_W-1:0] acc_mag, acc_bound;
  assign acc_mag   = acc[ACC_W-1] ? ACC_W'(-acc) : ACC_W'(acc);
  assign acc_bound = ACC_W'(cnt) << (SMP_W - 1);

  // R3: running sum stays within count times full scale
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mag <= acc_bound);
  // R4: count inside an open window stays below its length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_empty |-> cnt < len_act);
  // R4: idle cycles leave the window untouched
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> ($stable(acc) && $stable(cnt)));
endmodule

// File: rtl/wavg_divider.sv
module wavg_divider
  import wavg_pkg::*;
#(
  parameter int unsigned Q_W   = 16,
  parameter int unsigned LEN_W = 24,
  parameter int unsigned ACC_W = Q_W + LEN_W,
  parameter int unsigned RB    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [ACC_W-1:0] dividend,
  input  logic [LEN_W-1:0]        divisor,
  output logic                    done_o,
  output logic signed [Q_W-1:0]   quot_o
);
  localparam int unsigned STEPS = Q_W / RB;
  localparam int unsigned ST_W  = $clog2(STEPS + 1);
  localparam int unsigned PK_W  = LEN_W + 2 * Q_W;

  dv_state_e        state;
  logic [ST_W-1:0]  step;
  logic [LEN_W-1:0] rem, dvs;
  logic [Q_W-1:0]   lo, q;
  logic             neg;
  logic [ACC_W-1:0] mag;
  logic [PK_W-1:0]  adv;
  logic [LEN_W-1:0] rem_n;
  logic [Q_W-1:0]   lo_n, q_n;

  // RB restoring steps; quotient fits Q_W bits since |sum| <= N * 2^(Q_W-1)
  function automatic logic [PK_W-1:0] div_steps(input logic [LEN_W-1:0] r,
                                                 input logic [Q_W-1:0] l,
                                                 input logic [Q_W-1:0] qq,
                                                 input logic [LEN_W-1:0] d);
    logic [LEN_W:0] t;
    for (int i = 0; i < RB; i++) begin
      t = {r, l[Q_W-1]};
      l = l << 1;
      if (t >= {1'b0, d}) begin
        t  = t - {1'b0, d};
        qq = {qq[Q_W-2:0], 1'b1};
      end else begin
        qq = {qq[Q_W-2:0], 1'b0};
      end
      r = t[LEN_W-1:0];
    end
    return {r, l, qq};
  endfunction

  assign mag = dividend[ACC_W-1] ? ACC_W'(-dividend) : ACC_W'(dividend);
  assign adv = div_steps(rem, lo, q, dvs);
  assign {rem_n, lo_n, q_n} = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= DV_IDLE;
      step   <= '0;
      rem    <= '0;
      lo     <= '0;
      q      <= '0;
      dvs    <= '0;
      neg    <= 1'b0;
      done_o <= 1'b0;
      quot_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start) begin
        state <= DV_RUN;
        step  <= '0;
        rem   <= mag[ACC_W-1:Q_W];
        lo    <= mag[Q_W-1:0];
        q     <= '0;
        dvs   <= divisor;
        neg   <= dividend[ACC_W-1];
      end else if (state == DV_RUN) begin
        rem  <= rem_n;
        lo   <= lo_n;
        q    <= q_n;
        step <= step + 1'b1;
        if (step == ST_W'(STEPS - 1)) begin
          state  <= DV_IDLE;
          done_o <= 1'b1;
          quot_o <= neg ? -$signed(q_n) : $signed(q_n);
        end
      end
    end
  end

  // R6: a new window never closes while a division is in flight
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> state == DV_IDLE);
  // R5: last step is always followed by the result pulse
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DV_RUN && step == ST_W'(STEPS - 1) && !start) |=> done_o);
  // R5: result pulse lasts one cycle
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/win_avg_engine.sv
module win_avg_engine #(
  parameter int unsigned SMP_W      = 16,
  parameter int unsigned LEN_W      = 24,
  parameter int unsigned DEF_LEN    = wavg_pkg::DEF_LEN,
  parameter int unsigned MIN_LEN    = wavg_pkg::MIN_LEN,
  parameter int unsigned RADIX_BITS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic                    len_wr,
  input  logic [LEN_W-1:0]        len_wdata,
  output logic signed [SMP_W-1:0] avg_out,
  output logic                    avg_valid,
  output logic                    win_end
);
  localparam int unsigned ACC_W = SMP_W + LEN_W;

  logic [LEN_W-1:0]        len_pend, len_use;
  logic                    win_close;
  logic signed [ACC_W-1:0] win_sum;

  wavg_len_reg #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN), .MIN_LEN(MIN_LEN)) u_len (
    .clk(clk), .rst_n(rst_n), .wr(len_wr), .wdata(len_wdata), .len_pend(len_pend));

  wavg_accum #(.SMP_W(SMP_W), .LEN_W(LEN_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .valid(smp_valid), .data(smp_data),
    .len_pend(len_pend), .close_o(win_close), .sum_o(win_sum), .len_o(len_use));

  wavg_divider #(.Q_W(SMP_W), .LEN_W(LEN_W), .ACC_W(ACC_W), .RB(RADIX_BITS)) u_div (
    .clk(clk), .rst_n(rst_n), .start(win_close), .dividend(win_sum),
    .divisor(len_use), .done_o(avg_valid), .quot_o(avg_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_end <= 1'b0;
    else        win_end <= win_close;
  end

  // R4: boundary flag is a single-cycle pulse
  p_end_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !win_end);
  // R5: a result never coincides with a fresh window boundary
  p_end_no_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> !avg_valid);
endmodule

// File: tb/win_avg_engine_tb.sv
`timescale 1ns/1ps
module win_avg_engine_tb;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_valid = 1'b0;
  logic signed [15:0] smp_data = '0;
  logic               len_wr = 1'b0;
  logic [23:0]        len_wdata = '0;
  logic signed [15:0] avg_out;
  logic               avg_valid, win_end;

  win_avg_engine u_dut (.*);

  always #10 clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  longint msum = 0;
  int mcnt = 0, mcur = 0, mpend = 4000;
  logic exp_we = 1'b0;
  longint q_val[$];
  int q_due[$];

  function automatic int clamp_ref(int v);
    return (v < 10) ? 10 : v;
  endfunction

  function automatic longint mean_ref(longint s, int n);
    return s / n;  // truncates toward zero
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic step(input logic v, input logic signed [15:0] d, input logic w, input int wd);
    @(negedge clk);
    cyc++;
    if (exp_we || win_end) chk(win_end === exp_we, "R4 win_end", win_end, exp_we);
    if (avg_valid) begin
      if (q_val.size() == 0) chk(0, "R5 unexpected avg_valid", 1, 0);
      else begin
        chk(q_due[0] == cyc, "R5 latency cycle", cyc, q_due[0]);
        chk(avg_out == q_val[0], "R5/R3/R6 mean", avg_out, q_val[0]);
        void'(q_val.pop_front()); void'(q_due.pop_front());
      end
    end else if (q_due.size() != 0 && q_due[0] == cyc) begin
      chk(0, "R5 missing avg_valid", 0, 1);
      void'(q_val.pop_front()); void'(q_due.pop_front());
    end
    smp_valid = v; smp_data = d; len_wr = w; len_wdata = 24'(wd);
    exp_we = 1'b0;
    if (v) begin
      if (mcnt == 0) mcur = mpend;  // R7: length sampled at first sample
      msum += d; mcnt++;
      if (mcnt == mcur) begin
        q_val.push_back(mean_ref(msum, mcur));
        q_due.push_back(cyc + 9);
        exp_we = 1'b1;
        msum = 0; mcnt = 0;
      end
    end
    if (w) mpend = clamp_ref(wd);  // R2
  endtask

  task automatic close_window();
    while (mcnt != 0) step(1'b1, 16'sd0, 1'b0, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(avg_out == 0, "R1 avg_out", avg_out, 0);
    chk(avg_valid == 0, "R1 avg_valid", avg_valid, 0);
    chk(win_end == 0, "R1 win_end", win_end, 0);
    rst_n = 1'b1;
    // R8: default 4000-sample window
    for (int i = 0; i < 4000; i++) step(1'b1, 16'($urandom), 1'b0, 0);
    repeat (12) step(1'b0, 16'sd0, 1'b0, 0);
    // R2: write of 3 clamps to 10; R3 full scale negative
    step(1'b0, 16'sd0, 1'b1, 3);
    for (int i = 0; i < 10; i++) step(1'b1, -16'sd32768, 1'b0, 0);
    // R3 full scale positive, back to back (R6)
    for (int i = 0; i < 10; i++) step(1'b1, 16'sd32767, 1'b0, 0);
    // R2: write of 0 clamps to 10; R5 truncation toward zero
    step(1'b0, 16'sd0, 1'b1, 0);
    for (int i = 0; i < 9; i++) step(1'b1, 16'sd0, 1'b0, 0);
    step(1'b1, -16'sd15, 1'b0, 0);
    for (int i = 0; i < 9; i++) step(1'b1, 16'sd0, 1'b0, 0);
    step(1'b1, -16'sd5, 1'b0, 0);
    for (int i = 0; i < 9; i++) step(1'b1, 16'sd0, 1'b0, 0);
    step(1'b1, 16'sd15, 1'b0, 0);
    // R7: write on the same edge as a window's first sample
    step(1'b1, 16'sd100, 1'b1, 20);
    close_window();
    // R7: write mid-window, next window uses 12
    for (int i = 0; i < 5; i++) step(1'b1, 16'($urandom), 1'b0, 0);
    step(1'b1, 16'sd7, 1'b1, 12);
    close_window();
    for (int i = 0; i < 12; i++) step(1'b1, 16'($urandom), 1'b0, 0);
    // Random mix: gaps, writes, continuous streams (R4, R6, R7)
    for (int i = 0; i < 4000; i++) begin
      logic v, w;
      int wd;
      v  = ($urandom % 4) != 0;
      w  = ($urandom % 120) == 0;
      wd = (($urandom % 5) == 0) ? int'($urandom % 10) : 10 + int'($urandom % 30);
      step(v, 16'($urandom), w, wd);
    end
    close_window();
    repeat (15) step(1'b0, 16'sd0, 1'b0, 0);
    chk(q_val.size() == 0, "R6 all windows reported", q_val.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule